// File: doc/BRIEF.md
# Serial Display Byte Receiver

This block is the write-only serial front end of a small graphics display controller. A host drives an active-low chip select, a serial clock and a serial data line, and in four-wire operation also a line that marks each byte as display data or as a command. The block gathers eight serial bits into a byte and labels the byte as data or command. It then hands the byte to the core through a parallel bus with a one-cycle write strobe and a data/command flag, all in the system clock domain.

In three-wire operation the marking line is unused. Every byte is a command unless a data-length command has announced a string of display data bytes. This command is a two-byte sequence: an opcode byte, then a count byte. The announced number of bytes is flagged as data, and the byte after the string is a command again. The serial inputs are brought into the system clock through a multi-flop synchronizer. Serial edges are found on the synchronized clock, so the serial clock must run several times slower than the system clock.

Top module: `sdr_rx_top`

## Requirements
- R1: After reset the byte bus reads 0x00, the write strobe is low and the data flag is low.
- R2: Bits on the serial data line are taken on rising serial clock edges, most significant bit first. After the eighth edge the assembled byte appears on the byte bus without any further serial clock.
- R3: Each received byte produces a write strobe exactly one system clock long.
- R4: In four-wire mode (mode input 0) the data flag equals the level of the data/command line at the eighth edge of the byte, where 1 means display data and 0 means command.
- R5: While chip select is high, the bit counter is held at zero and no strobe is produced. A partial byte cut off by chip select going high is discarded.
- R6: In three-wire mode (mode input 1) the data/command line has no effect, and bytes outside a data string are flagged as commands.
- R7: In three-wire mode, the opcode byte 0xCA and the count byte after it are both flagged as commands. The next N bytes, where N is the count, are flagged as display data.
- R8: A count byte of 0x00 announces 256 data bytes.
- R9: After the last byte of a data string, the next byte is flagged as a command.
- R10: In four-wire mode the byte 0xCA does not start a data string; flags keep following the data/command line.
- R11: An extra serial clock edge while chip select stays low shifts the byte boundary for all later bytes until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wire3_i | input | 1 | Mode select: 1 three-wire, 0 four-wire |
| cs_n_i | input | 1 | Active-low chip select |
| sclk_i | input | 1 | Serial clock from the host |
| sdat_i | input | 1 | Serial data, MSB first |
| dc_i | input | 1 | Data(1)/command(0) marker, four-wire mode only |
| byte_o | output | 8 | Last received byte |
| wr_stb_o | output | 1 | One-cycle strobe per received byte |
| is_data_o | output | 1 | Flag of the strobed byte: 1 display data, 0 command |

## Verification
The hardest state to reach from the ports is the end of a maximal data string. The bench gets there by sending the length opcode with a zero count and then 256 data bytes, and it checks that only the byte after them comes back as a command. Broken byte alignment also cannot be seen directly. The bench creates it by sending one stray serial clock pulse, then checks the shifted values of the next two bytes and the return to normal alignment after reset.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

   typedef enum logic [1:0] {
      ST_CMD  = 2'd0,
      ST_CNT  = 2'd1,
      ST_DATA = 2'd2
   } rx_state_e;

   // index of each line inside the synchronized input vector
   localparam int unsigned IDX_DC   = 0;
   localparam int unsigned IDX_SDAT = 1;
   localparam int unsigned IDX_SCLK = 2;
   localparam int unsigned IDX_CSN  = 3;
   localparam int unsigned IDX_MODE = 4;
   localparam int unsigned IN_W     = 5;

endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   initial begin
      if (STAGES < 2) $error("sdr_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("sdr_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[gi] <= RST_VAL;
               else        stg_q[gi] <= async_i;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[gi] <= RST_VAL;
               else        stg_q[gi] <= stg_q[gi-1];
            end
         end
      end
   endgenerate

   assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/sdr_shifter.sv
module sdr_shifter #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              dc_s,
   output logic              byte_vld_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              dc_o
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   initial begin
      if (DATA_W < 2) $error("sdr_shifter: DATA_W must be at least 2");
      if ((1 << CNT_W) < DATA_W) $error("sdr_shifter: counter too narrow");
   end

   logic              sclk_d_q;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [DATA_W-2:0] shreg_q;
   logic              rise;

   assign rise = sclk_s & ~sclk_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d_q <= 1'b0;
      else        sclk_d_q <= sclk_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt_q <= '0;
         shreg_q   <= '0;
      end else if (cs_n_s) begin
         bit_cnt_q <= '0;
      end else if (rise) begin
         shreg_q <= {shreg_q[DATA_W-3:0], sdat_s};
         if (bit_cnt_q == LAST_BIT) bit_cnt_q <= '0;
         else                       bit_cnt_q <= bit_cnt_q + 1'b1;
      end
   end

   assign byte_vld_o = rise & ~cs_n_s & (bit_cnt_q == LAST_BIT);
   assign byte_o     = {shreg_q, sdat_s};
   assign dc_o       = dc_s;

endmodule

// File: rtl/sdr_classify.sv
module sdr_classify
   import sdr_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned MAX_LEN = 256,
   parameter logic [DATA_W-1:0] LEN_OPC = 8'hCA,
   localparam int unsigned LEN_W = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wire3_s,
   input  logic              byte_vld_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              dc_i,
   output logic [DATA_W-1:0] byte_o,
   output logic              wr_stb_o,
   output logic              is_data_o
);

   initial begin
      if (MAX_LEN != (1 << DATA_W))
         $error("sdr_classify: MAX_LEN must equal 2**DATA_W");
   end

   rx_state_e       st_q;
   logic [LEN_W-1:0] rem_q;
   logic [LEN_W-1:0] cnt_val;
   logic             flag_nxt;

   assign cnt_val  = (byte_i == '0) ? LEN_W'(MAX_LEN) : LEN_W'(byte_i);
   assign flag_nxt = wire3_s ? (st_q == ST_DATA) : dc_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_CMD;
         rem_q <= '0;
      end else if (!wire3_s) begin
         st_q  <= ST_CMD;
         rem_q <= '0;
      end else if (byte_vld_i) begin
         unique case (st_q)
            ST_CMD: begin
               if (byte_i == LEN_OPC) st_q <= ST_CNT;
            end
            ST_CNT: begin
               rem_q <= cnt_val;
               st_q  <= ST_DATA;
            end
            ST_DATA: begin
               rem_q <= rem_q - 1'b1;
               if (rem_q == LEN_W'(1)) st_q <= ST_CMD;
            end
            default: st_q <= ST_CMD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_o    <= '0;
         wr_stb_o  <= 1'b0;
         is_data_o <= 1'b0;
      end else begin
         wr_stb_o <= byte_vld_i;
         if (byte_vld_i) begin
            byte_o    <= byte_i;
            is_data_o <= flag_nxt;
         end
      end
   end

   // R8
   rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rem_q <= LEN_W'(MAX_LEN));

   // R9
   data_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA) |-> (rem_q != '0));

   // R6
   data_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb_o && is_data_o && $past(wire3_s)) |-> ($past(st_q) == ST_DATA));

endmodule

// File: rtl/sdr_rx_top.sv
module sdr_rx_top
   import sdr_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] LEN_OPC = 8'hCA,
   localparam int unsigned MAX_LEN = 1 << DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wire3_i,
   input  logic              cs_n_i,
   input  logic              sclk_i,
   input  logic              sdat_i,
   input  logic              dc_i,
   output logic [DATA_W-1:0] byte_o,
   output logic              wr_stb_o,
   output logic              is_data_o
);

   localparam logic [IN_W-1:0] SYNC_RST = IN_W'(1) << IDX_CSN;

   logic [IN_W-1:0]   raw_in;
   logic [IN_W-1:0]   syn_in;
   logic              byte_vld;
   logic [DATA_W-1:0] byte_asm;
   logic              dc_asm;

   always_comb begin
      raw_in           = '0;
      raw_in[IDX_DC]   = dc_i;
      raw_in[IDX_SDAT] = sdat_i;
      raw_in[IDX_SCLK] = sclk_i;
      raw_in[IDX_CSN]  = cs_n_i;
      raw_in[IDX_MODE] = wire3_i;
   end

   sdr_sync #(
      .WIDTH  (IN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(raw_in),
      .sync_o (syn_in)
   );

   sdr_shifter #(
      .DATA_W(DATA_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_s    (syn_in[IDX_CSN]),
      .sclk_s    (syn_in[IDX_SCLK]),
      .sdat_s    (syn_in[IDX_SDAT]),
      .dc_s      (syn_in[IDX_DC]),
      .byte_vld_o(byte_vld),
      .byte_o    (byte_asm),
      .dc_o      (dc_asm)
   );

   sdr_classify #(
      .DATA_W (DATA_W),
      .MAX_LEN(MAX_LEN),
      .LEN_OPC(LEN_OPC)
   ) u_class (
      .clk       (clk),
      .rst_n     (rst_n),
      .wire3_s   (syn_in[IDX_MODE]),
      .byte_vld_i(byte_vld),
      .byte_i    (byte_asm),
      .dc_i      (dc_asm),
      .byte_o    (byte_o),
      .wr_stb_o  (wr_stb_o),
      .is_data_o (is_data_o)
   );

   // R3
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |=> !wr_stb_o);

   // R5
   stb_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_o |-> !$past(syn_in[IDX_CSN]));

endmodule

// File: tb/sdr_rx_top_tb_top.sv
`timescale 1ns/1ps
module sdr_rx_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SER_HALF   = 6;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wire3 = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdat = 1'b0;
   logic       dc = 1'b0;
   logic [7:0] byte_o;
   logic       wr_stb_o;
   logic       is_data_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [7:0] cap_b [0:299];
   logic       cap_f [0:299];
   int         cap_n = 0;
   logic       stb_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdr_rx_top dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wire3_i  (wire3),
      .cs_n_i   (cs_n),
      .sclk_i   (sclk),
      .sdat_i   (sdat),
      .dc_i     (dc),
      .byte_o   (byte_o),
      .wr_stb_o (wr_stb_o),
      .is_data_o(is_data_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // capture monitor, sampled at the falling edge
   always @(negedge clk) begin
      cycles++;
      if (wr_stb_o) begin
         if (cap_n < 300) begin
            cap_b[cap_n] = byte_o;
            cap_f[cap_n] = is_data_o;
         end
         cap_n++;
      end
      if (stb_prev && wr_stb_o) begin
         checks++;
         errors++;
         $display("FAIL R3 strobe longer than one cycle: actual=2 expected=1");
      end
      stb_prev = wr_stb_o;
      if (cycles > WATCHDOG) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired: actual=%0d expected=%0d", cycles, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic do_reset();
      cs_n  = 1'b1;
      sclk  = 1'b0;
      rst_n = 1'b0;
      wait_clk(4);
      @(negedge clk);
      rst_n = 1'b1;
      wait_clk(4);
      cap_n = 0;
   endtask

   task automatic pulse(input logic b);
      @(negedge clk);
      sdat = b;
      wait_clk(SER_HALF);
      @(negedge clk);
      sclk = 1'b1;
      wait_clk(SER_HALF);
      @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v, input logic d);
      dc = d;
      for (int i = 7; i >= 0; i--) pulse(v[i]);
      wait_clk(8);
   endtask

   task automatic expect_cap(input int idx, input logic [7:0] v, input logic f,
                             input string req);
      chk(cap_b[idx] == v, req, $sformatf("byte %0d value", idx), cap_b[idx], v);
      chk(cap_f[idx] == f, req, $sformatf("byte %0d flag", idx), cap_f[idx], f);
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      chk(byte_o == 8'h00, "R1", "byte bus after reset", byte_o, 0);
      chk(wr_stb_o == 1'b0, "R1", "strobe after reset", wr_stb_o, 0);
      chk(is_data_o == 1'b0, "R1", "flag after reset", is_data_o, 0);
   endtask

   task automatic t_four_wire();
      wire3 = 1'b0;
      do_reset();
      @(negedge clk);
      cs_n = 1'b0;
      send_byte(8'hA5, 1'b1);
      // R2: strobe arrives with no extra serial clock after the eighth edge
      chk(cap_n == 1, "R2", "strobe count after one byte", cap_n, 1);
      send_byte(8'h3C, 1'b0);
      send_byte(8'hCA, 1'b0);
      send_byte(8'h81, 1'b1);
      send_byte(8'h07, 1'b1);
      chk(cap_n == 5, "R3", "strobes for five bytes", cap_n, 5);
      expect_cap(0, 8'hA5, 1'b1, "R2");
      expect_cap(1, 8'h3C, 1'b0, "R4");
      expect_cap(2, 8'hCA, 1'b0, "R4");
      // R10: opcode in four-wire mode starts no data string
      expect_cap(3, 8'h81, 1'b1, "R10");
      expect_cap(4, 8'h07, 1'b1, "R10");
      cs_n = 1'b1;
   endtask

   task automatic t_cs_abort();
      wire3 = 1'b0;
      do_reset();
      @(negedge clk);
      cs_n = 1'b0;
      dc = 1'b0;
      pulse(1'b1); pulse(1'b1); pulse(1'b1);
      @(negedge clk);
      cs_n = 1'b1;
      wait_clk(6);
      for (int i = 0; i < 8; i++) pulse(1'b1);
      wait_clk(8);
      chk(cap_n == 0, "R5", "strobes while deselected", cap_n, 0);
      @(negedge clk);
      cs_n = 1'b0;
      wait_clk(6);
      send_byte(8'h5A, 1'b1);
      chk(cap_n == 1, "R5", "strobes after reselect", cap_n, 1);
      expect_cap(0, 8'h5A, 1'b1, "R5");
      cs_n = 1'b1;
   endtask

   task automatic t_three_wire();
      wire3 = 1'b1;
      do_reset();
      @(negedge clk);
      cs_n = 1'b0;
      send_byte(8'h11, 1'b1);
      send_byte(8'hCA, 1'b1);
      send_byte(8'h03, 1'b1);
      send_byte(8'hD0, 1'b0);
      send_byte(8'hD1, 1'b0);
      send_byte(8'hD2, 1'b1);
      send_byte(8'h22, 1'b1);
      chk(cap_n == 7, "R7", "strobes in three-wire sequence", cap_n, 7);
      expect_cap(0, 8'h11, 1'b0, "R6");
      expect_cap(1, 8'hCA, 1'b0, "R7");
      expect_cap(2, 8'h03, 1'b0, "R7");
      expect_cap(3, 8'hD0, 1'b1, "R7");
      expect_cap(4, 8'hD1, 1'b1, "R7");
      expect_cap(5, 8'hD2, 1'b1, "R7");
      expect_cap(6, 8'h22, 1'b0, "R9");
      cs_n = 1'b1;
   endtask

   task automatic t_len_max();
      int ndata;
      int bad;
      wire3 = 1'b1;
      do_reset();
      @(negedge clk);
      cs_n = 1'b0;
      send_byte(8'hCA, 1'b0);
      send_byte(8'h00, 1'b0);
      for (int i = 0; i < 256; i++) send_byte(8'(i), 1'b0);
      send_byte(8'h44, 1'b1);
      chk(cap_n == 259, "R8", "strobes for 256-byte string", cap_n, 259);
      ndata = 0;
      bad = 0;
      for (int i = 2; i < 258; i++) begin
         if (cap_f[i]) ndata++;
         if (cap_b[i] != 8'(i - 2)) bad++;
      end
      chk(ndata == 256, "R8", "data-flagged bytes", ndata, 256);
      chk(bad == 0, "R8", "mismatched data bytes", bad, 0);
      expect_cap(1, 8'h00, 1'b0, "R8");
      expect_cap(258, 8'h44, 1'b0, "R9");
      cs_n = 1'b1;
   endtask

   task automatic t_glitch();
      wire3 = 1'b0;
      do_reset();
      @(negedge clk);
      cs_n = 1'b0;
      pulse(1'b1);
      send_byte(8'h00, 1'b0);
      send_byte(8'hFF, 1'b1);
      chk(cap_n == 2, "R11", "strobes after stray edge", cap_n, 2);
      expect_cap(0, 8'h80, 1'b0, "R11");
      expect_cap(1, 8'h7F, 1'b1, "R11");
      do_reset();
      @(negedge clk);
      cs_n = 1'b0;
      send_byte(8'h96, 1'b1);
      chk(cap_n == 1, "R11", "strobes after reset", cap_n, 1);
      expect_cap(0, 8'h96, 1'b1, "R11");
      cs_n = 1'b1;
   endtask

   initial begin
      t_reset();
      t_four_wire();
      t_cs_abort();
      t_three_wire();
      t_len_max();
      t_glitch();
      wait_clk(4);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule